// File: doc/BRIEF.md
# Multi-lane flash command sequencer

This block runs one serial flash command whenever a start pulse arrives while it is idle. A command is built from a descriptor presented on configuration inputs: an opcode, an optional 3- or 4-byte address, an optional run of dummy serial clocks, and up to eight data bytes that are either sent to or received from the flash. Phases whose count is zero are skipped. The opcode, address and write-data bytes can be sent over one, two or four data lanes. The whole descriptor is captured when the command starts, so software may rewrite the configuration while a command is running.

The sequencer does not generate the serial clock itself. A separate timing block toggles the flash clock while `sclk_run` is high and reports each clock's rising edge with `sclk_rise_stb` and each falling edge with `sclk_fall_stb`. The two strobes never occur in the same cycle, and a serial clock period starts with a rising strobe. Outgoing bits change only on the falling strobe, and incoming bits are sampled on the rising strobe. The data bus is split into output value, output enable and input value, so the pads can sit outside the block. Received bytes are packed into two 32-bit words that become visible only when a read command completes.

The package also exports the descriptor that the surrounding register file should reset to. This is a read-status command: opcode 0x05, no address, no dummy clocks, eight bytes read.

Top module: `flseq_cmd_seq`

## Requirements
- R1: When `start` is high while `busy` is low, `busy` and `sclk_run` go high and `cs_n` goes low on the next clock edge. All three hold until the falling strobe that ends the last serial clock of the command. On that edge `busy` and `sclk_run` drop and `cs_n` rises.
- R2: Phases run in this order: opcode, address, dummy, data. A phase whose count is zero is skipped. Let W be the number of lanes. The command lasts (8/W)·(1 + address bytes) + dummy + (8/W)·(data bytes) serial clocks.
- R3: An address count of 3 sends bits 23:0 of `cfg_addr`, and a count of 4 sends all 32 bits, most significant byte first. Any other address count gives no address phase.
- R4: Lane mode 0 uses DQ0 only, mode 1 uses DQ[1:0], and mode 2 uses DQ[3:0]. Mode 3 behaves as mode 0. The lane mode applies to the opcode, address and both data directions. Bytes go most significant bit first, and the highest active lane carries the most significant bit of each group. While driving, `dq_oe` is 0001, 0011 or 1111, and unused lanes output 0.
- R5: The dummy phase lasts `cfg_dummy` serial clocks (0 to 31). During it, `dq_oe` and `dq_out` are all zero.
- R6: `cfg_data_bytes` gives 0 to 8 data bytes, and values above 8 act as 8. `cfg_read` = 0 sends the bytes and `cfg_read` = 1 receives them.
- R7: Write byte k (k = 0..3) is taken from `cfg_wdata_lo[8k+7:8k]`, and byte k (k = 4..7) from `cfg_wdata_hi[8(k-4)+7:8(k-4)]`.
- R8: During the read-data phase, `dq_oe` and `dq_out` are zero. Bits are sampled on `sclk_rise_stb`: from DQ1 in one-lane mode, from DQ[1:0] (DQ1 most significant) in two-lane mode, and from DQ[3:0] (DQ3 most significant) in four-lane mode. Received byte k lands at the same bit positions that R7 gives for write byte k.
- R9: `rdata_lo`/`rdata_hi` change only on the edge where a read-direction command completes. Bytes that were not received read as zero. Write-direction commands leave them unchanged.
- R10: A start pulse while busy is ignored. Changes to any `cfg_*` input after a command has started have no effect on that command.
- R11: While idle, strobes have no effect: `cs_n` stays high, and `dq_oe` and `dq_out` stay zero.
- R12: After reset, `busy` and `sclk_run` are low, `cs_n` is high, `dq_oe` and `dq_out` are zero, and the read words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_opcode | input | 8 | Command opcode |
| cfg_addr_bytes | input | 3 | Address byte count (3 or 4; other values mean no address) |
| cfg_dummy | input | 5 | Dummy serial clocks |
| cfg_data_bytes | input | 4 | Data byte count (saturates at 8) |
| cfg_read | input | 1 | 1 = receive data bytes, 0 = send them |
| cfg_lane_mode | input | 2 | 0: one lane, 1: two lanes, 2: four lanes |
| cfg_addr | input | 32 | Flash address |
| cfg_wdata_lo | input | 32 | Write bytes 0..3 |
| cfg_wdata_hi | input | 32 | Write bytes 4..7 |
| start | input | 1 | Start request, honoured only while idle |
| sclk_rise_stb | input | 1 | Serial clock rising edge strobe (capture) |
| sclk_fall_stb | input | 1 | Serial clock falling edge strobe (launch) |
| busy | output | 1 | Command in progress |
| sclk_run | output | 1 | Request for the timing block to toggle the serial clock |
| cs_n | output | 1 | Flash chip select, active low |
| dq_out | output | 4 | Data lane output values |
| dq_oe | output | 4 | Data lane output enables |
| dq_in | input | 4 | Data lane input values |
| rdata_lo | output | 32 | Received bytes 0..3 |
| rdata_hi | output | 32 | Received bytes 4..7 |

## Verification
A wrong phase or byte index shows at the lane outputs within one serial clock, as a wrong bit group or an output enable that is on when it should be off. A wrong beat or dummy count shows at the end of the command, as a total clock count that differs from the formula in R2. A fault in the read packing stays hidden until the read words update when `busy` falls, so it is caught by comparing all eight bytes after every read command, including commands that receive fewer than eight bytes. Faults in descriptor capture or start gating appear only when the configuration or `start` changes in the middle of a command, so one command is disturbed on purpose.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

    localparam int BYTE_W     = 8;
    localparam int LANES      = 4;
    localparam int DATA_BYTES = 8;
    localparam int WORD_W     = 32;
    localparam int DATA_W     = DATA_BYTES * BYTE_W;
    localparam int ADDR_W     = 32;
    localparam int ADRCNT_W   = 3;
    localparam int DUMMY_W    = 5;
    localparam int DCNT_W     = $clog2(DATA_BYTES + 1);
    localparam int IDX_W      = $clog2(DATA_BYTES);
    localparam int BEAT_W     = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    typedef enum logic [1:0] {
        LN_W1,
        LN_W2,
        LN_W4
    } lane_e;

    typedef struct packed {
        logic [BYTE_W-1:0]   opcode;
        logic [ADRCNT_W-1:0] addr_bytes;
        logic [DUMMY_W-1:0]  dummy;
        logic [DCNT_W-1:0]   data_bytes;
        logic                rd;
        lane_e               lane;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
    } desc_t;

    typedef struct packed {
        phase_e              phase;
        logic [IDX_W-1:0]    idx;
        logic [BEAT_W-1:0]   beat;
        logic [DUMMY_W-1:0]  dcnt;
        logic [BYTE_W-1:0]   sh;
        desc_t               desc;
    } seq_st_t;

    // Descriptor a register file should load at reset: read-status command
    localparam desc_t DESC_DEFAULT = '{
        opcode:     8'h05,
        addr_bytes: '0,
        dummy:      '0,
        data_bytes: DCNT_W'(DATA_BYTES),
        rd:         1'b1,
        lane:       LN_W1,
        addr:       '0,
        wdata:      '0
    };

    // Phase that follows p, skipping empty phases
    function automatic phase_e phase_after(phase_e p, desc_t d);
        logic   has_a;
        logic   has_m;
        logic   has_d;
        phase_e dph;
        has_a = (d.addr_bytes != '0);
        has_m = (d.dummy != '0);
        has_d = (d.data_bytes != '0);
        dph   = d.rd ? PH_RDATA : PH_WDATA;
        case (p)
            PH_OPC:   phase_after = has_a ? PH_ADDR :
                                    (has_m ? PH_DUMMY : (has_d ? dph : PH_IDLE));
            PH_ADDR:  phase_after = has_m ? PH_DUMMY : (has_d ? dph : PH_IDLE);
            PH_DUMMY: phase_after = has_d ? dph : PH_IDLE;
            default:  phase_after = PH_IDLE;
        endcase
    endfunction

    // Index of the last serial clock inside one byte
    function automatic logic [BEAT_W-1:0] last_beat(lane_e l);
        case (l)
            LN_W2:   last_beat = BEAT_W'(BYTE_W / 2 - 1);
            LN_W4:   last_beat = BEAT_W'(BYTE_W / 4 - 1);
            default: last_beat = BEAT_W'(BYTE_W - 1);
        endcase
    endfunction

endpackage

// File: rtl/flseq_byte_sel.sv
module flseq_byte_sel import flseq_pkg::*; (
    input  desc_t              desc,
    input  phase_e             ph,
    input  logic [IDX_W-1:0]   idx,
    output logic [BYTE_W-1:0]  tx_byte
);

    logic [$clog2(ADDR_W)-1:0] adr_shift;
    logic [$clog2(DATA_W)-1:0] dat_shift;

    always_comb begin
        adr_shift = $bits(adr_shift)'((int'(desc.addr_bytes) - 1 - int'(idx)) * BYTE_W);
        dat_shift = $bits(dat_shift)'(int'(idx) * BYTE_W);
        case (ph)
            PH_OPC:   tx_byte = desc.opcode;
            PH_ADDR:  tx_byte = BYTE_W'(desc.addr >> adr_shift);
            PH_WDATA: tx_byte = BYTE_W'(desc.wdata >> dat_shift);
            default:  tx_byte = '0;
        endcase
    end

endmodule

// File: rtl/flseq_lane_drv.sv
module flseq_lane_drv import flseq_pkg::*; (
    input  phase_e             ph,
    input  lane_e              lane,
    input  logic [BYTE_W-1:0]  sh,
    output logic [LANES-1:0]   dq_out,
    output logic [LANES-1:0]   dq_oe
);

    logic drive;

    always_comb begin
        drive  = (ph == PH_OPC) || (ph == PH_ADDR) || (ph == PH_WDATA);
        dq_out = '0;
        dq_oe  = '0;
        if (drive) begin
            case (lane)
                LN_W2: begin
                    dq_out[1:0] = sh[BYTE_W-1 -: 2];
                    dq_oe[1:0]  = 2'b11;
                end
                LN_W4: begin
                    dq_out[3:0] = sh[BYTE_W-1 -: 4];
                    dq_oe[3:0]  = 4'b1111;
                end
                default: begin
                    dq_out[0] = sh[BYTE_W-1];
                    dq_oe[0]  = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/flseq_rx_pack.sv
module flseq_rx_pack import flseq_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               sample,
    input  lane_e              lane,
    input  logic [LANES-1:0]   dq_in,
    input  logic               byte_done,
    input  logic [IDX_W-1:0]   idx,
    input  logic               commit,
    output logic [DATA_W-1:0]  rdata
);

    typedef struct packed {
        logic [BYTE_W-1:0] rx_byte;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] rdata;
    } rx_st_t;

    rx_st_t rx_d, rx_q;

    always_comb begin
        rx_d = rx_q;
        if (clear) begin
            rx_d.rx_byte = '0;
            rx_d.acc     = '0;
        end
        if (sample) begin
            case (lane)
                LN_W2:   rx_d.rx_byte = {rx_q.rx_byte[BYTE_W-3:0], dq_in[1:0]};
                LN_W4:   rx_d.rx_byte = {rx_q.rx_byte[BYTE_W-5:0], dq_in[3:0]};
                default: rx_d.rx_byte = {rx_q.rx_byte[BYTE_W-2:0], dq_in[1]};
            endcase
        end
        if (byte_done) begin
            rx_d.acc[int'(idx) * BYTE_W +: BYTE_W] = rx_q.rx_byte;
            rx_d.rx_byte = '0;
        end
        if (commit) begin
            rx_d.rdata = rx_d.acc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign rdata = rx_q.rdata;

endmodule

// File: rtl/flseq_cmd_seq.sv
module flseq_cmd_seq import flseq_pkg::*; (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BYTE_W-1:0]    cfg_opcode,
    input  logic [ADRCNT_W-1:0]  cfg_addr_bytes,
    input  logic [DUMMY_W-1:0]   cfg_dummy,
    input  logic [DCNT_W-1:0]    cfg_data_bytes,
    input  logic                 cfg_read,
    input  logic [1:0]           cfg_lane_mode,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata_lo,
    input  logic [WORD_W-1:0]    cfg_wdata_hi,
    input  logic                 start,
    input  logic                 sclk_rise_stb,
    input  logic                 sclk_fall_stb,
    output logic                 busy,
    output logic                 sclk_run,
    output logic                 cs_n,
    output logic [LANES-1:0]     dq_out,
    output logic [LANES-1:0]     dq_oe,
    input  logic [LANES-1:0]     dq_in,
    output logic [WORD_W-1:0]    rdata_lo,
    output logic [WORD_W-1:0]    rdata_hi
);

    localparam seq_st_t ST_RESET = '{
        phase: PH_IDLE,
        idx:   '0,
        beat:  '0,
        dcnt:  '0,
        sh:    '0,
        desc:  DESC_DEFAULT
    };

    seq_st_t            st_d, st_q;
    desc_t              cfg_norm;
    phase_e             adv_ph;
    logic [IDX_W-1:0]   adv_idx;
    logic [BYTE_W-1:0]  adv_byte;
    logic               beat_end;
    logic               dummy_end;
    logic               accept;
    logic               finish;
    logic [DATA_W-1:0]  rdata_w;

    // Descriptor normalisation at the configuration inputs
    always_comb begin
        cfg_norm.opcode     = cfg_opcode;
        cfg_norm.addr_bytes = (cfg_addr_bytes == ADRCNT_W'(3) || cfg_addr_bytes == ADRCNT_W'(4))
                              ? cfg_addr_bytes : '0;
        cfg_norm.dummy      = cfg_dummy;
        cfg_norm.data_bytes = (cfg_data_bytes > DCNT_W'(DATA_BYTES))
                              ? DCNT_W'(DATA_BYTES) : cfg_data_bytes;
        cfg_norm.rd         = cfg_read;
        case (cfg_lane_mode)
            2'd1:    cfg_norm.lane = LN_W2;
            2'd2:    cfg_norm.lane = LN_W4;
            default: cfg_norm.lane = LN_W1;
        endcase
        cfg_norm.addr       = cfg_addr;
        cfg_norm.wdata      = {cfg_wdata_hi, cfg_wdata_lo};
    end

    // Where the sequence goes at the end of the current byte or dummy run
    always_comb begin
        beat_end  = (st_q.beat == last_beat(st_q.desc.lane));
        dummy_end = (st_q.dcnt == st_q.desc.dummy - DUMMY_W'(1));
        adv_ph    = st_q.phase;
        adv_idx   = st_q.idx + IDX_W'(1);
        case (st_q.phase)
            PH_OPC, PH_DUMMY: begin
                adv_ph  = phase_after(st_q.phase, st_q.desc);
                adv_idx = '0;
            end
            PH_ADDR: begin
                if (st_q.idx == IDX_W'(st_q.desc.addr_bytes - ADRCNT_W'(1))) begin
                    adv_ph  = phase_after(st_q.phase, st_q.desc);
                    adv_idx = '0;
                end
            end
            PH_WDATA, PH_RDATA: begin
                if (DCNT_W'(st_q.idx) == st_q.desc.data_bytes - DCNT_W'(1)) begin
                    adv_ph  = PH_IDLE;
                    adv_idx = '0;
                end
            end
            default: begin
                adv_ph  = PH_IDLE;
                adv_idx = '0;
            end
        endcase
    end

    flseq_byte_sel u_byte_sel (
        .desc    (st_q.desc),
        .ph      (adv_ph),
        .idx     (adv_idx),
        .tx_byte (adv_byte)
    );

    // Next-state computation
    always_comb begin
        st_d   = st_q;
        accept = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    accept     = 1'b1;
                    st_d.desc  = cfg_norm;
                    st_d.phase = PH_OPC;
                    st_d.idx   = '0;
                    st_d.beat  = '0;
                    st_d.dcnt  = '0;
                    st_d.sh    = cfg_opcode;
                end
            end
            PH_DUMMY: begin
                if (sclk_fall_stb) begin
                    if (dummy_end) begin
                        st_d.phase = adv_ph;
                        st_d.idx   = adv_idx;
                        st_d.beat  = '0;
                        st_d.dcnt  = '0;
                        st_d.sh    = adv_byte;
                    end else begin
                        st_d.dcnt  = st_q.dcnt + DUMMY_W'(1);
                    end
                end
            end
            default: begin
                if (sclk_fall_stb) begin
                    if (beat_end) begin
                        st_d.phase = adv_ph;
                        st_d.idx   = adv_idx;
                        st_d.beat  = '0;
                        st_d.dcnt  = '0;
                        st_d.sh    = adv_byte;
                    end else begin
                        st_d.beat  = st_q.beat + BEAT_W'(1);
                        case (st_q.desc.lane)
                            LN_W2:   st_d.sh = st_q.sh << 2;
                            LN_W4:   st_d.sh = st_q.sh << 4;
                            default: st_d.sh = st_q.sh << 1;
                        endcase
                    end
                end
            end
        endcase
        finish = (st_q.phase != PH_IDLE) && (st_d.phase == PH_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    flseq_lane_drv u_lane_drv (
        .ph     (st_q.phase),
        .lane   (st_q.desc.lane),
        .sh     (st_q.sh),
        .dq_out (dq_out),
        .dq_oe  (dq_oe)
    );

    flseq_rx_pack u_rx_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .sample    (sclk_rise_stb && (st_q.phase == PH_RDATA)),
        .lane      (st_q.desc.lane),
        .dq_in     (dq_in),
        .byte_done (sclk_fall_stb && (st_q.phase == PH_RDATA) && beat_end),
        .idx       (st_q.idx),
        .commit    (finish && st_q.desc.rd),
        .rdata     (rdata_w)
    );

    assign busy     = (st_q.phase != PH_IDLE);
    assign sclk_run = busy;
    assign cs_n     = ~busy;
    assign rdata_lo = rdata_w[WORD_W-1:0];
    assign rdata_hi = rdata_w[DATA_W-1:WORD_W];

endmodule

// File: rtl/flseq_cmd_seq_chk.sv
module flseq_cmd_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        sclk_fall_stb,
    input logic        busy,
    input logic        cs_n,
    input logic [3:0]  dq_out,
    input logic [3:0]  dq_oe,
    input logic [31:0] rdata_lo,
    input logic [31:0] rdata_hi
);

    // R1: an idle start always opens a command
    p_start_opens_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R1: a command never opens without a start request
    p_rise_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4: lane outputs move only on the launch strobe
    p_launch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(sclk_fall_stb)) |-> ($stable(dq_out) && $stable(dq_oe)));

    // R4: output enables are a contiguous group from lane 0
    p_oe_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b0011 || dq_oe == 4'b1111));

    // R9: read words move only when a command ends
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> ($stable(rdata_lo) && $stable(rdata_hi)));

    // R11: quiet bus while idle
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n && dq_oe == 4'b0000 && dq_out == 4'b0000));

endmodule

bind flseq_cmd_seq flseq_cmd_seq_chk i_flseq_cmd_seq_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .sclk_fall_stb (sclk_fall_stb),
    .busy          (busy),
    .cs_n          (cs_n),
    .dq_out        (dq_out),
    .dq_oe         (dq_oe),
    .rdata_lo      (rdata_lo),
    .rdata_hi      (rdata_hi)
);

// File: tb/test_flseq_cmd_seq.sv
module test_flseq_cmd_seq;

    typedef struct packed {
        logic [7:0]  opcode;
        logic [2:0]  abytes;
        logic [4:0]  dummy;
        logic [3:0]  nbytes;
        logic        rd;
        logic [1:0]  lane;
        logic [31:0] addr;
        logic [63:0] wdata;
        logic [63:0] rpat;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h05, 3'd0, 5'd0,  4'd8,  1'b1, 2'd0, 32'h0000_0000, 64'h0, 64'h8877_6655_4433_2211},
        '{8'h0B, 3'd3, 5'd8,  4'd4,  1'b1, 2'd0, 32'hA512_3456, 64'h0, 64'hDEAD_BEEF_C3A5_5A3C},
        '{8'h32, 3'd4, 5'd0,  4'd8,  1'b0, 2'd2, 32'h89AB_CDEF, 64'h0123_4567_89AB_CDEF, 64'h0},
        '{8'hBB, 3'd3, 5'd4,  4'd5,  1'b1, 2'd1, 32'h0012_3456, 64'h0, 64'h1122_3344_5566_7788},
        '{8'h06, 3'd0, 5'd0,  4'd0,  1'b0, 2'd0, 32'h0000_0000, 64'h0, 64'h0},
        '{8'h9F, 3'd2, 5'd0,  4'd12, 1'b0, 2'd3, 32'hFFFF_FFFF, 64'hF0E1_D2C3_B4A5_9687, 64'h0},
        '{8'hEC, 3'd4, 5'd31, 4'd8,  1'b1, 2'd2, 32'h0102_0304, 64'h0, 64'h5AA5_0FF0_3CC3_9669},
        '{8'h3B, 3'd3, 5'd1,  4'd0,  1'b1, 2'd1, 32'h00AB_CDEF, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_opcode = '0;
    logic [2:0]  cfg_addr_bytes = '0;
    logic [4:0]  cfg_dummy = '0;
    logic [3:0]  cfg_data_bytes = '0;
    logic        cfg_read = 1'b0;
    logic [1:0]  cfg_lane_mode = '0;
    logic [31:0] cfg_addr = '0;
    logic [31:0] cfg_wdata_lo = '0;
    logic [31:0] cfg_wdata_hi = '0;
    logic        start = 1'b0;
    logic        sclk_rise_stb = 1'b0;
    logic        sclk_fall_stb = 1'b0;
    logic        busy;
    logic        sclk_run;
    logic        cs_n;
    logic [3:0]  dq_out;
    logic [3:0]  dq_oe;
    logic [3:0]  dq_in = 4'b0110;
    logic [31:0] rdata_lo;
    logic [31:0] rdata_hi;

    int          n_checks = 0;
    int          n_fail = 0;
    logic        done = 1'b0;
    logic [63:0] prev_rdata = '0;

    always #10 clk = ~clk;

    flseq_cmd_seq i_flseq_cmd_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_opcode     (cfg_opcode),
        .cfg_addr_bytes (cfg_addr_bytes),
        .cfg_dummy      (cfg_dummy),
        .cfg_data_bytes (cfg_data_bytes),
        .cfg_read       (cfg_read),
        .cfg_lane_mode  (cfg_lane_mode),
        .cfg_addr       (cfg_addr),
        .cfg_wdata_lo   (cfg_wdata_lo),
        .cfg_wdata_hi   (cfg_wdata_hi),
        .start          (start),
        .sclk_rise_stb  (sclk_rise_stb),
        .sclk_fall_stb  (sclk_fall_stb),
        .busy           (busy),
        .sclk_run       (sclk_run),
        .cs_n           (cs_n),
        .dq_out         (dq_out),
        .dq_oe          (dq_oe),
        .dq_in          (dq_in),
        .rdata_lo       (rdata_lo),
        .rdata_hi       (rdata_hi)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One serial clock: rising strobe, then falling strobe
    task automatic serial_clock(input logic [3:0] din, input bit poke_start);
        dq_in         = din;
        sclk_rise_stb = 1'b1;
        if (poke_start) start = 1'b1;
        @(negedge clk);
        sclk_rise_stb = 1'b0;
        start         = 1'b0;
        sclk_fall_stb = 1'b1;
        @(negedge clk);
        sclk_fall_stb = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input bit disturb);
        int          w, cpb, na, nd, hdr, rd_start, total, c, mism, k, bt, bits, mask;
        logic [7:0]  txb [0:12];
        logic [3:0]  eo, eoe, din;
        logic [7:0]  byt;
        logic [63:0] exp_rd, bad_act, bad_exp;
        bit          rd_moved;
        w    = (v.lane == 2'd1) ? 2 : ((v.lane == 2'd2) ? 4 : 1);
        cpb  = 8 / w;
        mask = (1 << w) - 1;
        na   = (v.abytes == 3'd3 || v.abytes == 3'd4) ? int'(v.abytes) : 0;
        nd   = (v.nbytes > 4'd8) ? 8 : int'(v.nbytes);
        hdr  = cpb * (1 + na);
        rd_start = hdr + int'(v.dummy);
        total    = rd_start + cpb * nd;
        for (int i = 0; i < 13; i++) txb[i] = 8'h00;
        txb[0] = v.opcode;
        for (int i = 0; i < na; i++) txb[1 + i] = 8'(v.addr >> (8 * (na - 1 - i)));
        for (int i = 0; i < nd; i++) txb[1 + na + i] = 8'(v.wdata >> (8 * i));

        cfg_opcode     = v.opcode;
        cfg_addr_bytes = v.abytes;
        cfg_dummy      = v.dummy;
        cfg_data_bytes = v.nbytes;
        cfg_read       = v.rd;
        cfg_lane_mode  = v.lane;
        cfg_addr       = v.addr;
        cfg_wdata_lo   = v.wdata[31:0];
        cfg_wdata_hi   = v.wdata[63:32];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1 && cs_n === 1'b0 && sclk_run === 1'b1, "R1", "open after start",
            {61'b0, busy, cs_n, sclk_run}, 64'b101);
        if (disturb) begin
            cfg_opcode     = 8'h00;
            cfg_lane_mode  = 2'd2;
            cfg_addr_bytes = 3'd0;
            cfg_dummy      = 5'd3;
            cfg_data_bytes = 4'd0;
            cfg_read       = ~v.rd;
        end

        c = 0; mism = 0; rd_moved = 0; bad_act = '0; bad_exp = '0;
        while (busy === 1'b1 && c < 1000) begin
            eo = 4'b0; eoe = 4'b0; din = 4'b0110;
            if (c < hdr) begin
                byt = txb[c / cpb]; bt = c % cpb;
                bits = (int'(byt) >> (8 - w * (bt + 1))) & mask;
                eo = 4'(bits); eoe = 4'(mask);
            end else if (c >= rd_start) begin
                k = c - rd_start; bt = k % cpb;
                if (!v.rd) begin
                    byt = txb[1 + na + k / cpb];
                    bits = (int'(byt) >> (8 - w * (bt + 1))) & mask;
                    eo = 4'(bits); eoe = 4'(mask);
                end else begin
                    byt = 8'(v.rpat >> (8 * (k / cpb)));
                    bits = (int'(byt) >> (8 - w * (bt + 1))) & mask;
                    if (w == 1)      din = {~bits[0], ~bits[0], bits[0], ~bits[0]};
                    else if (w == 2) din = {~bits[1], ~bits[0], bits[1:0]};
                    else             din = 4'(bits);
                end
            end
            if (dq_out !== eo || dq_oe !== eoe) begin
                if (mism == 0) begin
                    bad_act = {32'(c), 24'b0, dq_oe, dq_out};
                    bad_exp = {32'(c), 24'b0, eoe, eo};
                end
                mism++;
            end
            if ({rdata_hi, rdata_lo} !== prev_rdata) rd_moved = 1;
            serial_clock(din, disturb && c == 3);
            c++;
        end

        chk(mism == 0, "R2 R3 R4 R5 R7 R8", "lane values per serial clock (clk,oe,out)",
            bad_act, bad_exp);
        chk(c == total, "R2 R6", "serial clocks in command", 64'(c), 64'(total));
        chk(cs_n === 1'b1 && sclk_run === 1'b0 && dq_oe === 4'b0, "R1", "released at end",
            {60'b0, cs_n, sclk_run, 2'b0}, {60'b0, 1'b1, 1'b0, 2'b0});
        chk(!rd_moved, "R9", "read words steady while busy", 64'(rd_moved), 64'd0);
        exp_rd = prev_rdata;
        if (v.rd) begin
            exp_rd = '0;
            for (int i = 0; i < nd; i++) exp_rd |= v.rpat & (64'hFF << (8 * i));
        end
        chk({rdata_hi, rdata_lo} === exp_rd, v.rd ? "R8 R9" : "R9", "read words after command",
            {rdata_hi, rdata_lo}, exp_rd);
        prev_rdata = exp_rd;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && cs_n === 1'b1 && sclk_run === 1'b0 && dq_oe === 4'b0 &&
            dq_out === 4'b0 && {rdata_hi, rdata_lo} === 64'b0, "R12", "reset state",
            {busy, cs_n, sclk_run, dq_oe, dq_out, 1'b0, rdata_lo[19:0]}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && cs_n === 1'b1, "R12", "idle after reset release",
            {62'b0, busy, cs_n}, 64'b01);

        // R11: strobes while idle leave the bus quiet
        for (int i = 0; i < 4; i++) serial_clock(4'b1111, 1'b0);
        chk(busy === 1'b0 && cs_n === 1'b1 && dq_oe === 4'b0 && dq_out === 4'b0, "R11",
            "idle strobes", {54'b0, busy, cs_n, dq_oe, dq_out}, 64'h100);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

        // R10: start and new configuration mid-command are ignored
        run_vec(VECS[3], 1'b1);
        for (int i = 0; i < 3; i++) serial_clock(4'b0000, 1'b0);
        chk(busy === 1'b0 && cs_n === 1'b1, "R10", "no second command after stray start",
            {62'b0, busy, cs_n}, 64'b01);

        // R9: a write command after a read keeps the read words
        run_vec(VECS[2], 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule